// File: doc/BRIEF.md
# Synchronous FIFO with Retransmit

This block is a single-clock, single-direction first-in first-out buffer built on an inferred dual-port memory. The write side and the read side each have a chip select and an enable. Both status flags are active low: `empty_n` is low when nothing can be read, and `full_n` is low when nothing can be written. Read data is registered and changes on the clock edge that accepts a read.

A retransmit request rewinds the read side to the first word written since the last reset, so the stored stream can be replayed. The write side is not affected. A request is honoured only while no more than DEPTH-2 words have been written since the last master or partial reset. When a request is honoured, the controller runs a fixed setup sequence. State `S_RUN` moves to `S_SET1` on an accepted request. `S_SET1` always moves to `S_SET2`, and `S_SET2` always returns to `S_RUN`. `empty_n` is held low in `S_SET1` and `S_SET2`, so reads are blocked. A request that breaks the depth limit leaves the state in `S_RUN` and produces a one-cycle error pulse.

A master reset (asynchronous) clears everything, including the output data register. A partial reset (synchronous) empties the FIFO and restarts the depth-limit window, but keeps the last output word.

Top module: `sync_fifo_rt`

## Requirements
- R1: While and after `mrst_n` is low, `empty_n`=0, `full_n`=1, `rd_data`=0 and `rt_err`=0.
- R2: Accepted reads return words in write order. `rd_data` takes the new word on the edge that accepts the read and holds it otherwise.
- R3: A write is accepted only when `wr_cs_n`=0, `wr_en`=1 and `full_n`=1. `full_n` is 0 exactly when DEPTH words are held, and a write attempted then is dropped.
- R4: A read is accepted only when `rd_cs_n`=0, `rd_en`=1 and `empty_n`=1. When `empty_n` is 0, `rd_data` and the read position do not change.
- R5: With `wr_cs_n`=1 a write enable is ignored, and with `rd_cs_n`=1 a read enable is ignored.
- R6: A retransmit request is a clock edge in `S_RUN` with `rd_cs_n`=0, `rt_strobe`=1 and `rt_mode`=1. When the request is honoured, `empty_n` is 0 for the two cycles after that edge. It then follows occupancy again.
- R7: After an honoured retransmit, the next reads return the words from the first word written since the last reset onward. Words written before and during setup stay stored.
- R8: If more than DEPTH-2 words were written since the last reset, a request is ignored: no setup runs, reads continue from where they were, and `rt_err` is 1 for exactly the cycle after the request edge.
- R9: A partial reset (`prst_n`=0 at an edge) empties the FIFO, cancels any setup and restarts the write window. `rd_data` keeps its value.
- R10: A request with `rt_mode`=0 or with `rd_cs_n`=1 has no effect.
- R11: A read enable in the cycle of an honoured retransmit request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| wr_cs_n | input | 1 | Write-side chip select, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | WIDTH | Write data |
| full_n | output | 1 | Low when DEPTH words are held |
| rd_cs_n | input | 1 | Read-side chip select, active low; also qualifies retransmit |
| rd_en | input | 1 | Read enable |
| rd_data | output | WIDTH | Registered read data |
| empty_n | output | 1 | Low when empty or during retransmit setup |
| rt_strobe | input | 1 | Retransmit strobe |
| rt_mode | input | 1 | Retransmit mode qualifier |
| rt_err | output | 1 | One-cycle pulse when a request breaks the depth limit |

## Verification
The hardest situation to reach from the ports is the boundary of the depth limit. A request must come after exactly DEPTH-2 or DEPTH-1 writes since a reset, and a read must already have been taken so that a rewind and an ignored request can be told apart.

The bench therefore sweeps the write count from zero to DEPTH-1 on a small configuration. Each pass starts with a partial reset, takes one read where possible, and then issues the request. It then replays or continues reading and compares every word against an arithmetic model. Reads are also attempted inside the two setup cycles and in the request cycle itself.

// File: rtl/fifo_rt_pkg.sv
`timescale 1ns / 1ps
package fifo_rt_pkg;
    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_SET1 = 2'd1,
        S_SET2 = 2'd2
    } rt_state_t;
endpackage

// File: rtl/fifo_rt_mem.sv
`timescale 1ns / 1ps
module fifo_rt_mem #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Output register: cleared only by master reset.
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/fifo_rt_ctrl.sv
`timescale 1ns / 1ps
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int LIMIT = DEPTH - 2
) (
    input  logic      clk,
    input  logic      mrst_n,
    input  logic      prst_n,
    input  logic      rt_req,
    input  logic      wr_acc,
    output rt_state_t state,
    output logic      rt_go,
    output logic      rt_err
);
    rt_state_t   state_nx;
    logic        err_nx;
    logic [AW-1:0] wr_since;   // saturates at DEPTH-1

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            wr_since <= '0;
        end else if (!prst_n) begin
            wr_since <= '0;
        end else if (wr_acc && (wr_since != AW'(DEPTH - 1))) begin
            wr_since <= wr_since + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        rt_go    = 1'b0;
        err_nx   = 1'b0;
        unique case (state)
            S_RUN: begin
                if (rt_req) begin
                    if (wr_since <= AW'(LIMIT)) begin
                        rt_go    = 1'b1;
                        state_nx = S_SET1;
                    end else begin
                        err_nx = 1'b1;
                    end
                end
            end
            S_SET1:  state_nx = S_SET2;
            S_SET2:  state_nx = S_RUN;
            default: state_nx = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            state <= S_RUN;
        end else if (!prst_n) begin
            state <= S_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            rt_err <= 1'b0;
        end else if (!prst_n) begin
            rt_err <= 1'b0;
        end else begin
            rt_err <= err_nx;
        end
    end
endmodule

// File: rtl/sync_fifo_rt.sv
`timescale 1ns / 1ps
module sync_fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             wr_cs_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full_n,
    input  logic             rd_cs_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    input  logic             rt_strobe,
    input  logic             rt_mode,
    output logic             rt_err
);
    rt_state_t   state;
    logic        rt_req;
    logic        rt_go;
    logic        wr_acc;
    logic        rd_acc;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] cnt;

    assign rt_req  = !rd_cs_n && rt_strobe && rt_mode;
    assign cnt     = wr_ptr - rd_ptr;
    assign empty_n = (state == S_RUN) && (cnt != '0);
    assign full_n  = (cnt != PW'(DEPTH));
    assign wr_acc  = !wr_cs_n && wr_en && full_n;
    assign rd_acc  = !rd_cs_n && rd_en && empty_n && !rt_go;

    fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .mrst_n (mrst_n),
        .prst_n (prst_n),
        .rt_req (rt_req),
        .wr_acc (wr_acc),
        .state  (state),
        .rt_go  (rt_go),
        .rt_err (rt_err)
    );

    fifo_rt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .mrst_n (mrst_n),
        .we     (wr_acc),
        .waddr  (wr_ptr[AW-1:0]),
        .wdata  (wr_data),
        .re     (rd_acc),
        .raddr  (rd_ptr[AW-1:0]),
        .rdata  (rd_data)
    );

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            wr_ptr <= '0;
        end else if (!prst_n) begin
            wr_ptr <= '0;
        end else if (wr_acc) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Rewind goes to the reset base address, zero.
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            rd_ptr <= '0;
        end else if (!prst_n) begin
            rd_ptr <= '0;
        end else if (rt_go) begin
            rd_ptr <= '0;
        end else if (rd_acc) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/fifo_rt_chk.sv
`timescale 1ns / 1ps
module fifo_rt_chk
    import fifo_rt_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 2048,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             rd_cs_n,
    input logic             rt_strobe,
    input logic             rt_mode,
    input logic             empty_n,
    input logic             full_n,
    input logic [WIDTH-1:0] rd_data,
    input logic             rt_err,
    input logic             rt_go,
    input rt_state_t        state,
    input logic [PW-1:0]    rd_ptr,
    input logic [PW-1:0]    wr_ptr,
    input logic [PW-1:0]    cnt
);
    logic port_req;
    assign port_req = !rd_cs_n && rt_strobe && rt_mode;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!mrst_n)
        cnt <= PW'(DEPTH));

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && !full_n) |=> $stable(wr_ptr));

    p_empty_blocks_r4: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && !empty_n && !port_req) |=> ($stable(rd_ptr) && $stable(rd_data)));

    p_setup_first_r6: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && rt_go) |=> (state == S_SET1));

    p_setup_second_r6: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && state == S_SET1) |=> (state == S_SET2));

    p_setup_empty_r6: assert property (@(posedge clk) disable iff (!mrst_n)
        (state != S_RUN) |-> !empty_n);

    p_go_from_run_r6: assert property (@(posedge clk) disable iff (!mrst_n)
        rt_go |-> (state == S_RUN));

    p_rewind_base_r7: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && rt_go) |=> (rd_ptr == '0));

    p_err_no_setup_r8: assert property (@(posedge clk) disable iff (!mrst_n)
        rt_err |-> (state == S_RUN && $past(state) == S_RUN));
endmodule

bind sync_fifo_rt fifo_rt_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .rd_cs_n   (rd_cs_n),
    .rt_strobe (rt_strobe),
    .rt_mode   (rt_mode),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .rd_data   (rd_data),
    .rt_err    (rt_err),
    .rt_go     (rt_go),
    .state     (state),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .cnt       (cnt)
);

// File: tb/test_sync_fifo_rt.sv
`timescale 1ns / 1ps
module test_sync_fifo_rt;
    localparam int W = 16;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         prst_n = 1'b1;
    logic         wr_cs_n = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         full_n;
    logic         rd_cs_n = 1'b1;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         empty_n;
    logic         rt_strobe = 1'b0;
    logic         rt_mode = 1'b0;
    logic         rt_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    int m_wr = 0, m_rd = 0, m_setup = 0, m_gen = 0, m_data = 0, m_err = 0;

    always #2.5 clk = ~clk;

    sync_fifo_rt #(.WIDTH(W), .DEPTH(D)) i_sync_fifo_rt (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n),
        .rt_strobe(rt_strobe), .rt_mode(rt_mode), .rt_err(rt_err)
    );

    function automatic int word_of(int gen, int idx);
        return ((gen & 8'hFF) << 8) | (idx & 8'hFF);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, "rd_data", int'(rd_data), m_data);
        chk(tag, "empty_n", int'(empty_n), int'(m_setup == 0 && m_wr != m_rd));
        chk(tag, "full_n", int'(full_n), int'((m_wr - m_rd) != D));
        chk(tag, "rt_err", int'(rt_err), m_err);
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(bit w, bit wcs, bit r, bit rcs, bit stb, bit mode, string tag);
        bit req, go, wacc, racc;
        int occ;
        wr_en = w; wr_cs_n = wcs; rd_en = r; rd_cs_n = rcs;
        rt_strobe = stb; rt_mode = mode;
        wr_data = W'(word_of(m_gen, m_wr));
        occ  = m_wr - m_rd;
        req  = !rcs && stb && mode && (m_setup == 0);
        go   = req && (m_wr <= D - 2);
        wacc = w && !wcs && (occ != D);
        racc = r && !rcs && (m_setup == 0) && (occ != 0) && !go;
        @(posedge clk);
        if (racc) begin
            m_data = word_of(m_gen, m_rd);
            m_rd++;
        end
        if (wacc) m_wr++;
        if (m_setup > 0) m_setup--;
        if (go) begin
            m_setup = 2;
            m_rd = 0;
        end
        m_err = int'(req && !go);
        @(negedge clk);
        wr_en = 0; wr_cs_n = 1; rd_en = 0; rd_cs_n = 1; rt_strobe = 0; rt_mode = 0;
        chk_all(tag);
    endtask

    task automatic master_reset();
        mrst_n = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "rd_data in reset", int'(rd_data), 0);
        chk("R1", "empty_n in reset", int'(empty_n), 0);
        mrst_n = 1;
        m_wr = 0; m_rd = 0; m_setup = 0; m_data = 0; m_err = 0; m_gen++;
        chk_all("R1");
    endtask

    task automatic part_reset();
        prst_n = 0;
        @(posedge clk);
        @(negedge clk);
        prst_n = 1;
        m_wr = 0; m_rd = 0; m_setup = 0; m_err = 0; m_gen++;
        chk_all("R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        master_reset();
        // R4: read while empty
        step(0, 1, 1, 0, 0, 0, "R4");
        // R3: fill, then overfill
        for (int i = 0; i < D + 2; i++) step(1, 0, 0, 1, 0, 0, "R3");
        // R5: deselected write and read
        step(1, 1, 1, 1, 0, 0, "R5");
        // R2: drain in order
        for (int i = 0; i < D + 1; i++) step(0, 1, 1, 0, 0, 0, "R2");
        // R2: simultaneous read and write streams
        for (int i = 0; i < 12; i++) step(1, 0, i[0], 0, 0, 0, "R2");
        for (int i = 0; i < D; i++) step(0, 1, 1, 0, 0, 0, "R2");
        // R1: master reset mid-run clears data
        master_reset();
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 0, "R2");
        // R9: partial reset keeps rd_data
        part_reset();
        for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, 0, "R9");
        // R10: disqualified requests
        step(0, 1, 1, 0, 1, 0, "R10");
        step(0, 1, 0, 1, 1, 1, "R10");
        step(0, 1, 1, 0, 0, 0, "R10");
        // R11 + R6: request with read in the same cycle, then reads during setup
        step(0, 1, 1, 0, 1, 1, "R11");
        step(1, 0, 1, 0, 0, 0, "R6");
        step(1, 0, 1, 0, 0, 0, "R6");
        // R7: replay from the first word
        for (int i = 0; i < D + 1; i++) step(0, 1, 1, 0, 0, 0, "R7");
        // R8 and R6/R7 sweep over write counts
        for (int n = 0; n < D; n++) begin
            part_reset();
            for (int i = 0; i < n; i++) step(1, 0, 0, 1, 0, 0, "R8");
            if (n > 0) step(0, 1, 1, 0, 0, 0, "R7");
            step(0, 1, 0, 0, 1, 1, (n > D - 2) ? "R8" : "R6");
            step(0, 1, 1, 0, 0, 0, "R6");
            step(0, 1, 1, 0, 0, 0, "R6");
            for (int i = 0; i < D; i++) step(1, 0, 0, 1, 0, 0, "R3");
            for (int i = 0; i < D + 1; i++) step(0, 1, 1, 0, 0, 0, "R7");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule